// File: doc/BRIEF.md
# Interruptible Iterative Divider

A sequential divider that produces a 16-bit quotient and a 16-bit remainder from either a 32-bit or a 16-bit dividend and a 16-bit divisor. Operands can be treated as unsigned or as two's complement. In fractional mode the 16-bit dividend and divisor are read as Q15 values and the quotient is a Q15 value. The divider computes one quotient bit per step using the restoring method.

A start pulse captures the operands and mode bits. After that, the divider moves forward only on clock edges where `stepEn` is high. A complete operation takes exactly 19 enabled steps: one setup step, 16 quotient-bit steps, one range-check step and one sign-fix/output step. The enable can be held low for any number of cycles between steps. All partial state stays in registers, so a host can pause the divide (for example while it services an interrupt) and later resume it with no change to the result.

If the divisor is zero, or the result does not fit the 16-bit quotient format, the block raises `overflow` and returns all ones in both outputs. The outputs and flags stay unchanged until the next start.

Top module: `iter_divider`

## Requirements
- R1: After reset, `busy`, `done` and `overflow` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` pulse captures the operands and mode bits and sets `busy`=1 and `done`=0. `done` becomes 1 and `busy` becomes 0 right after the edge of the 19th enabled step (an edge with `stepEn`=1) that follows the start, and not earlier.
- R3: An edge with `stepEn`=0 does not advance the operation. Any number of such stall edges between steps leaves the step count and the final result unchanged.
- R4: Integer mode with `longMode`=1 and `signedMode`=0 returns quotient = floor(N/D) and remainder = N mod D, where N is the full 32-bit dividend.
- R5: Integer mode with `longMode`=0 uses only `dividendIn[15:0]` and ignores `dividendIn[31:16]`.
- R6: With `signedMode`=1, operands are two's complement. The quotient is truncated toward zero, and a non-zero remainder has the sign of the dividend.
- R7: With `fracMode`=1, the dividend a = `dividendIn[15:0]` and the divisor b are Q15 values (signed, or unsigned per `signedMode`). The quotient is trunc(a·2^15 / b) and the remainder is a·2^15 − quotient·b. In this mode `longMode` and `dividendIn[31:16]` are ignored.
- R8: In fractional mode, if |a| ≥ |b|, `overflow` is set.
- R9: A zero divisor sets `overflow`. Whenever `overflow` is 1, `quotient` and `remainder` are both 16'hFFFF.
- R10: In integer mode, `overflow` is set when the true quotient is outside 0..65535 (unsigned) or outside −32768..32767 (signed).
- R11: Once `done` is 1, the outputs and flags do not change until the next `start`. `stepEn` and operand changes have no effect during this time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture operands and begin a divide |
| stepEn | input | 1 | Advance one step on this edge |
| dividendIn | input | 32 | Dividend (low half only in short or fractional mode) |
| divisorIn | input | 16 | Divisor |
| longMode | input | 1 | 1: 32/16 divide, 0: 16/16 divide |
| signedMode | input | 1 | Two's complement operands |
| fracMode | input | 1 | Q15 fractional divide |
| quotient | output | 16 | Quotient result |
| remainder | output | 16 | Remainder result |
| busy | output | 1 | Divide in progress |
| done | output | 1 | Result valid |
| overflow | output | 1 | Result not representable or divisor zero |

## Verification
The divider is run with unsigned 32/16 operands whose high half is close to the divisor. These separate a correct restore decision on every bit from an off-by-one compare. Signed cases cover all four sign combinations, so a swapped remainder sign or a flooring quotient shows up. Fractional cases separate the Q15 alignment from integer scaling and include the |a| = |b| boundary. Zero divisors and −32768/−1 check the overflow paths. Every case runs under random stall patterns, plus a long stall just before the last step. Together these show that the result and the 19-step count do not depend on when the steps arrive, and that results held after `done` ignore stray enables.

// File: rtl/iter_div_pkg.sv
package iter_div_pkg;
  // Extra steps beyond one per quotient bit: setup, range check, sign fix.
  localparam int DIV_OVERHEAD = 3;

  typedef struct packed {
    logic load;
    logic setup;
    logic iter;
    logic fix;
    logic finish;
  } divStrobe_t;
endpackage

// File: rtl/iter_div_ctrl.sv
module iter_div_ctrl
  import iter_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       stepEn,
  output divStrobe_t stb,
  output logic       busy,
  output logic       done
);
  localparam int TOTAL = W + DIV_OVERHEAD;
  localparam int CW    = $clog2(TOTAL);
  localparam logic [CW-1:0] LAST    = CW'(TOTAL - 1);
  localparam logic [CW-1:0] FIX_AT  = CW'(W + 1);

  logic [CW-1:0] stepCnt;
  logic          adv;

  assign adv = busy && stepEn && !start;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      stepCnt <= '0;
      busy    <= 1'b1;
      done    <= 1'b0;
    end else if (adv) begin
      if (stepCnt == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb        = '0;
    stb.load   = start;
    stb.setup  = adv && (stepCnt == '0);
    stb.iter   = adv && (stepCnt != '0) && (stepCnt < FIX_AT);
    stb.fix    = adv && (stepCnt == FIX_AT);
    stb.finish = adv && (stepCnt == LAST);
  end

  // R2: done only rises on the last enabled step
  p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(stepCnt) == LAST) && $past(stepEn));

  // R2: busy and done are exclusive
  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R3: a stalled edge holds the step position
  p_stall_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stepEn && !start) |=> $stable(stepCnt) && busy);

  // R11: once done, nothing moves without a start
  p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done && !busy);
endmodule

// File: rtl/iter_div_dp.sv
module iter_div_dp
  import iter_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  divStrobe_t     stb,
  input  logic [2*W-1:0] dividendIn,
  input  logic [W-1:0]   divisorIn,
  input  logic           longMode,
  input  logic           signedMode,
  input  logic           fracMode,
  output logic [W-1:0]   quotOut,
  output logic [W-1:0]   remOut,
  output logic           ovfOut
);
  localparam int DW = 2 * W;
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  // captured operands
  logic [DW-1:0] opN;
  logic [W-1:0]  opD;
  logic          sgnReg, fracReg, longReg;

  // working state
  logic [W-1:0]  pRem, qReg, absDReg;
  logic          negQ, negR, ovfReg;

  // setup decode
  logic          nNeg, dNeg;
  logic [W-1:0]  magShort, absD;
  logic [DW-1:0] magLong, shortExt, absN;
  logic          setupOvf;

  always_comb begin
    nNeg     = sgnReg && ((longReg && !fracReg) ? opN[DW-1] : opN[W-1]);
    dNeg     = sgnReg && opD[W-1];
    magShort = nNeg ? (~opN[W-1:0] + 1'b1) : opN[W-1:0];
    magLong  = nNeg ? (~opN + 1'b1) : opN;
    absD     = dNeg ? (~opD + 1'b1) : opD;
    shortExt = {{W{1'b0}}, magShort};
    if (fracReg)      absN = shortExt << (W - 1);
    else if (longReg) absN = magLong;
    else              absN = shortExt;
    setupOvf = (opD == '0) || (absN[DW-1:W] >= absD) ||
               (fracReg && (magShort >= absD));
  end

  // one restoring step
  logic [W:0] trial, diff;
  logic       geD;
  always_comb begin
    trial = {pRem, qReg[W-1]};
    diff  = trial - {1'b0, absDReg};
    geD   = trial >= {1'b0, absDReg};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opN <= '0; opD <= '0;
      sgnReg <= 1'b0; fracReg <= 1'b0; longReg <= 1'b0;
      pRem <= '0; qReg <= '0; absDReg <= '0;
      negQ <= 1'b0; negR <= 1'b0; ovfReg <= 1'b0;
      quotOut <= '0; remOut <= '0; ovfOut <= 1'b0;
    end else begin
      if (stb.load) begin
        opN     <= dividendIn;
        opD     <= divisorIn;
        sgnReg  <= signedMode;
        fracReg <= fracMode;
        longReg <= longMode;
        ovfOut  <= 1'b0;
      end
      if (stb.setup) begin
        pRem    <= absN[DW-1:W];
        qReg    <= absN[W-1:0];
        absDReg <= absD;
        negQ    <= nNeg ^ dNeg;
        negR    <= nNeg;
        ovfReg  <= setupOvf;
      end
      if (stb.iter) begin
        pRem <= geD ? diff[W-1:0] : trial[W-1:0];
        qReg <= {qReg[W-2:0], geD};
      end
      if (stb.fix) begin
        if (sgnReg && ((negQ && (qReg > MIN_NEG)) || (!negQ && qReg[W-1])))
          ovfReg <= 1'b1;
      end
      if (stb.finish) begin
        ovfOut  <= ovfReg;
        quotOut <= ovfReg ? '1 : (negQ ? (~qReg + 1'b1) : qReg);
        remOut  <= ovfReg ? '1 : (negR ? (~pRem + 1'b1) : pRem);
      end
    end
  end

  // R4: partial remainder stays below the divisor during iteration
  p_rem_bounded_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.iter && !ovfReg) |-> (pRem < absDReg));

  // R9: overflow forces all-ones results
  p_ovf_all_ones_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.finish) && ovfOut) |-> (quotOut == '1) && (remOut == '1));

  // R6: non-zero signed remainder carries the dividend sign
  p_rem_sign_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.finish) && !ovfOut && sgnReg && (remOut != '0))
      |-> (remOut[W-1] == negR));

  // R3: without a step strobe the working state holds
  p_state_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.load || stb.setup || stb.iter || stb.fix || stb.finish)
      |=> $stable(pRem) && $stable(qReg) && $stable(ovfReg));
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import iter_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           stepEn,
  input  logic [2*W-1:0] dividendIn,
  input  logic [W-1:0]   divisorIn,
  input  logic           longMode,
  input  logic           signedMode,
  input  logic           fracMode,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           busy,
  output logic           done,
  output logic           overflow
);
  divStrobe_t stb;

  iter_div_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .stepEn(stepEn),
    .stb(stb), .busy(busy), .done(done)
  );

  iter_div_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .longMode(longMode), .signedMode(signedMode), .fracMode(fracMode),
    .quotOut(quotient), .remOut(remainder), .ovfOut(overflow)
  );
endmodule

// File: tb/iter_divider_tb.sv
module iter_divider_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        start, stepEn, longMode, signedMode, fracMode;
  logic [31:0] dividendIn;
  logic [15:0] divisorIn;
  logic [15:0] quotient, remainder;
  logic        busy, done, overflow;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk; // 125 MHz

  iter_divider dut_i (
    .clk(clk), .rstN(rstN), .start(start), .stepEn(stepEn),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .longMode(longMode), .signedMode(signedMode), .fracMode(fracMode),
    .quotient(quotient), .remainder(remainder),
    .busy(busy), .done(done), .overflow(overflow)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent reference from the requirements
  task automatic refModel(input logic [31:0] n, input logic [15:0] d,
                          input bit lng, input bit sg, input bit fr,
                          output logic [15:0] q, output logic [15:0] r,
                          output bit o);
    longint a, b, qq, rr;
    b = sg ? longint'($signed(d)) : longint'(d);
    if (fr || !lng) a = sg ? longint'($signed(n[15:0])) : longint'(n[15:0]);
    else            a = sg ? longint'($signed(n)) : longint'(n);
    o = 1'b0;
    if (b == 0) o = 1'b1;
    else if (fr) begin
      if ((a < 0 ? -a : a) >= (b < 0 ? -b : b)) o = 1'b1;
      else begin
        qq = (a * 32768) / b;
        rr = a * 32768 - qq * b;
      end
    end else begin
      qq = a / b;
      rr = a - qq * b;
      if (sg ? (qq < -32768 || qq > 32767) : (qq > 65535)) o = 1'b1;
    end
    if (o) begin q = 16'hFFFF; r = 16'hFFFF; end
    else begin q = qq[15:0]; r = rr[15:0]; end
  endtask

  // one divide with stalls; stallPct in percent, tailStall before last step
  task automatic runDiv(input string req, input logic [31:0] n, input logic [15:0] d,
                        input bit lng, input bit sg, input bit fr,
                        input int stallPct, input int tailStall);
    logic [15:0] eq, er;
    bit eo, early, en;
    int steps;
    refModel(n, d, lng, sg, fr, eq, er, eo);
    @(negedge clk);
    dividendIn = n; divisorIn = d; longMode = lng; signedMode = sg; fracMode = fr;
    start = 1'b1; stepEn = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check({req, " R2 busy after start"}, busy, 1);
    check({req, " R2 done clear after start"}, done, 0);
    dividendIn = ~n; divisorIn = ~d; // captured values must be used
    steps = 0; early = 0;
    while (steps < 19) begin
      if (steps == 18 && tailStall > 0) begin
        stepEn = 1'b0;
        repeat (tailStall) @(negedge clk);
        check({req, " R3 no completion during stall"}, done, 0);
        check({req, " R3 still busy during stall"}, busy, 1);
      end
      en = ($urandom_range(99) >= stallPct);
      stepEn = en;
      @(posedge clk);
      if (en) steps++;
      @(negedge clk);
      if (steps < 19 && done) early = 1;
    end
    stepEn = 1'b0;
    check({req, " R2 no early done"}, early, 0);
    check({req, " R2 done after 19 steps"}, done, 1);
    check({req, " R2 busy cleared"}, busy, 0);
    check({req, " quotient"}, quotient, eq);
    check({req, " remainder"}, remainder, er);
    check({req, " overflow"}, overflow, eo);
  endtask

  task automatic testReset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 overflow", overflow, 0);
    check("R1 quotient", quotient, 0);
    check("R1 remainder", remainder, 0);
  endtask

  task automatic testUnsignedLong();
    runDiv("R4 u32", 32'd1000000, 16'd7, 1, 0, 0, 0, 0);
    runDiv("R4 u32 near", 32'h1233FFFF, 16'h1234, 1, 0, 0, 30, 0);
    runDiv("R4 u32 max", 32'hFFFEFFFF, 16'hFFFF, 1, 0, 0, 50, 5);
  endtask

  task automatic testShort();
    runDiv("R5 u16 high ignored", 32'hABCD0064, 16'd9, 0, 0, 0, 20, 0);
    runDiv("R5 s16 high ignored", 32'h5555FF9C, 16'd7, 0, 1, 0, 20, 3);
  endtask

  task automatic testSigned();
    runDiv("R6 pos/neg", 32'd100, 16'hFFF9, 1, 1, 0, 40, 0);
    runDiv("R6 neg/pos", -32'sd100, 16'd7, 1, 1, 0, 40, 0);
    runDiv("R6 neg/neg", -32'sd100000, 16'hFFF9, 1, 1, 0, 40, 10);
    runDiv("R6 min16 ok", -32'sd32768, 16'd1, 1, 1, 0, 10, 0);
  endtask

  task automatic testFrac();
    runDiv("R7 frac s", 32'h00002000, 16'h4000, 0, 1, 1, 30, 0);
    runDiv("R7 frac neg", 32'hFFFFE000, 16'h3000, 1, 1, 1, 30, 4);
    runDiv("R7 frac u", 32'h77770123, 16'h8001, 1, 0, 1, 30, 0);
    runDiv("R8 frac equal", 32'h00004000, 16'h4000, 0, 1, 1, 20, 0);
    runDiv("R8 frac m1m1", 32'h00008000, 16'h8000, 0, 1, 1, 20, 0);
  endtask

  task automatic testOverflow();
    runDiv("R9 zero div", 32'd1234, 16'd0, 1, 0, 0, 20, 0);
    runDiv("R9 zero div signed", 32'd5, 16'd0, 0, 1, 0, 20, 0);
    runDiv("R10 u32 too big", 32'h00010000, 16'd1, 1, 0, 0, 20, 0);
    runDiv("R10 s16 min/-1", 32'h00008000, 16'hFFFF, 0, 1, 0, 20, 2);
    runDiv("R10 s32 pos big", 32'd40000, 16'd1, 1, 1, 0, 20, 0);
  endtask

  task automatic testHold();
    logic [15:0] q0, r0;
    runDiv("R11 setup", 32'd5000, 16'd3, 1, 0, 0, 0, 0);
    q0 = quotient; r0 = remainder;
    dividendIn = 32'd9; divisorIn = 16'd2; stepEn = 1'b1;
    repeat (25) @(negedge clk);
    stepEn = 1'b0;
    check("R11 quotient held", quotient, q0);
    check("R11 remainder held", remainder, r0);
    check("R11 done held", done, 1);
    check("R11 busy stays low", busy, 0);
  endtask

  task automatic testRestart();
    runDiv("R2 restart after overflow", 32'd77, 16'd0, 0, 0, 0, 0, 0);
    runDiv("R2 clean after overflow", 32'd77, 16'd5, 0, 0, 0, 60, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    nTests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; stepEn = 1'b0;
    longMode = 1'b0; signedMode = 1'b0; fracMode = 1'b0;
    dividendIn = '0; divisorIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnsignedLong();
    testShort();
    testSigned();
    testFrac();
    testOverflow();
    testHold();
    testRestart();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule